// File: doc/BRIEF.md
# Switchable Audio Master-Clock NCO

This block is a numerically controlled oscillator that runs from one fast reference clock. It synthesizes a 256x-oversampled audio master clock for either the 48 kHz sample-rate family (12.288 MHz) or the 44.1 kHz family (11.2896 MHz). A 32-bit phase accumulator advances by an increment on every reference cycle, and the master clock is the registered most significant bit of that accumulator. The output frequency is therefore f_ref x increment / 2^32. Each output edge lands on a reference edge, so edge jitter stays within one reference period.

A one-bit family input picks one of two preset increments. Each preset is computed at elaboration as round(f_out x 2^32 / f_ref) from the reference frequency parameter. A second input switches to an arbitrary increment supplied on a bus. The chosen increment is first captured in a shadow register. It is moved into the active register only on the reference cycle in which the accumulator wraps. A switch therefore never cuts a high or low phase short.

Besides the master clock, the block gives a one-reference-cycle tick on every master-clock rising edge and a sample strobe on every 256th tick. The strobe runs at 48 kHz or 44.1 kHz.

Top module: `audio_mclk_nco`

## Requirements
- R1: While rst_n is low at a clock edge, mclk, mclk_tick and fs_tick are all 0 after that edge, and the accumulator restarts from zero.
- R2: With use_custom = 0 and fam_sel = 0, the increment is round(12 288 000 x 2^32 / REF_HZ). Over a long window, the number of master-clock rising edges is within one of window x increment / 2^32.
- R3: With use_custom = 0 and fam_sel = 1, the increment is round(11 289 600 x 2^32 / REF_HZ), with the same long-window rate tolerance as R2.
- R4: With use_custom = 1, the increment is custom_inc (unsigned, ACC_W bits) and fam_sel has no effect.
- R5: A changed selection reaches the accumulator only on the cycle it wraps. A high or low phase in progress keeps the old rate, and across any switch no high or low phase is shorter than floor(2^(ACC_W-1) / inc) for the smaller of the two phases involved.
- R6: mclk_tick is high for exactly one reference cycle, in the first cycle in which mclk is high after being low.
- R7: fs_tick is high only together with mclk_tick, on the 256th tick after reset and every 256 ticks after that.
- R8: With a fixed increment, every master-clock period is floor or ceil of 2^ACC_W / inc reference cycles, and every high and low phase is floor or ceil of 2^(ACC_W-1) / inc cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fam_sel | input | 1 | Rate family: 0 = 48 kHz family, 1 = 44.1 kHz family |
| use_custom | input | 1 | 1 = use custom_inc instead of a preset |
| custom_inc | input | ACC_W (32) | Arbitrary phase increment |
| mclk | output | 1 | Master clock, registered accumulator MSB |
| mclk_tick | output | 1 | One-cycle pulse on each mclk rising edge |
| fs_tick | output | 1 | One-cycle sample strobe every 256 ticks |

## Verification
The two presets are each held for a long window. The tick count is compared with the rate expected from the preset formula, and every period and phase length is checked against the floor/ceil bound. This separates a wrong preset, a wrong family decode and a broken accumulator. A custom increment of exactly 2^30 gives a 4-cycle period with no fractional part. It pins down the custom path and the 256-tick strobe spacing with exact numbers. The family input is toggled repeatedly at irregular distances, and a custom/preset mix is toggled as well, to look for runt phases. A deterministic increment of 2^28 is switched right after a rising edge: the high phase must still last the full 8 cycles, which shows the update waits for the wrap.

// File: rtl/nco_pkg.sv
// Package: shared helpers for the audio master-clock NCO.
// Assumes f_out << f_ref and ACC_W small enough that f_out * 2^(ACC_W+1)
// fits in 64 bits (true for audio rates and ACC_W up to 34).
package nco_pkg;

    // Rounded increment: round(f_out * 2^w / f_ref), computed in integers.
    function automatic logic [63:0] calc_inc(input logic [63:0] f_out,
                                             input logic [63:0] f_ref,
                                             input int unsigned w);
        logic [63:0] scaled;
        scaled = f_out << (w + 1);
        return ((scaled / f_ref) + 64'd1) >> 1;
    endfunction

endpackage

// File: rtl/nco_inc_ctrl.sv
// Increment control: picks a preset or the custom increment, captures it in
// a shadow register every cycle and moves it to the active register only when
// the accumulator reports a wrap. Assumes wrap is a single-cycle qualifier
// from the accumulator in the same clock domain.
module nco_inc_ctrl #(
    parameter int unsigned      ACC_W    = 32,
    parameter logic [ACC_W-1:0] INC_FAM0 = '0,
    parameter logic [ACC_W-1:0] INC_FAM1 = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fam_sel,
    input  logic             use_custom,
    input  logic [ACC_W-1:0] custom_inc,
    input  logic             wrap,
    output logic [ACC_W-1:0] active_inc
);
    logic [ACC_W-1:0] want_inc;
    logic [ACC_W-1:0] shadow_inc;

    // Purpose: decode the requested increment from the control inputs.
    always_comb begin
        if (use_custom)   want_inc = custom_inc;
        else if (fam_sel) want_inc = INC_FAM1;
        else              want_inc = INC_FAM0;
    end

    // Purpose: shadow follows the request; active loads only on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_inc <= INC_FAM0;
            active_inc <= INC_FAM0;
        end else begin
            shadow_inc <= want_inc;
            if (wrap) active_inc <= shadow_inc;
        end
    end

    AST_HOLD_UNTIL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(active_inc)); // R5

endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator: adds the active increment each cycle, reports the
// carry-out as wrap, and registers the MSB as the master clock with a
// rising-edge tick. Assumes inc is nonzero and below 2^(ACC_W-1).
module nco_phase_acc #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc,
    output logic             wrap,
    output logic             mclk,
    output logic             mclk_tick
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;

    // Purpose: next phase and carry-out of the addition.
    always_comb begin
        {wrap, acc_sum} = {1'b0, acc} + {1'b0, inc};
    end

    // Purpose: advance phase, register the MSB and detect its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            mclk      <= 1'b0;
            mclk_tick <= 1'b0;
        end else begin
            acc       <= acc_sum;
            mclk      <= acc[ACC_W-1];
            mclk_tick <= acc[ACC_W-1] & ~mclk;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_tick |=> !mclk_tick); // R6
    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_tick |-> (mclk && !$past(mclk))); // R6

endmodule

// File: rtl/nco_fs_div.sv
// Sample-rate divider: counts master-clock ticks and raises a strobe on every
// 2^DIV_W-th tick. The strobe is the AND of two registered signals and is
// meant only for synchronous use in the reference domain.
module nco_fs_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic fs_tick
);
    localparam logic [DIV_W-1:0] LAST = '1;

    logic [DIV_W-1:0] tick_cnt;

    // Purpose: count ticks modulo 2^DIV_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_cnt <= '0;
        else if (tick) tick_cnt <= tick_cnt + 1'b1;
    end

    // Purpose: strobe on the tick that closes a full count.
    always_comb fs_tick = tick && (tick_cnt == LAST);

    AST_FS_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fs_tick |-> tick); // R7
    AST_FS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fs_tick |=> (tick_cnt == '0)); // R7

endmodule

// File: rtl/audio_mclk_nco.sv
// Top: switchable 256x audio master-clock synthesizer. Derives both preset
// increments from REF_HZ at elaboration and wires the increment control,
// phase accumulator and sample-rate divider. Assumes REF_HZ well above twice
// the highest master frequency.
module audio_mclk_nco #(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned REF_HZ  = 250_000_000,
    parameter int unsigned FAM0_HZ = 12_288_000,
    parameter int unsigned FAM1_HZ = 11_289_600,
    parameter int unsigned DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fam_sel,
    input  logic             use_custom,
    input  logic [ACC_W-1:0] custom_inc,
    output logic             mclk,
    output logic             mclk_tick,
    output logic             fs_tick
);
    import nco_pkg::*;

    localparam logic [63:0] INC0_W = calc_inc(64'(FAM0_HZ), 64'(REF_HZ), ACC_W);
    localparam logic [63:0] INC1_W = calc_inc(64'(FAM1_HZ), 64'(REF_HZ), ACC_W);
    localparam logic [ACC_W-1:0] INC_FAM0 = INC0_W[ACC_W-1:0];
    localparam logic [ACC_W-1:0] INC_FAM1 = INC1_W[ACC_W-1:0];

    logic [ACC_W-1:0] active_inc;
    logic             wrap;

    nco_inc_ctrl #(
        .ACC_W   (ACC_W),
        .INC_FAM0(INC_FAM0),
        .INC_FAM1(INC_FAM1)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fam_sel   (fam_sel),
        .use_custom(use_custom),
        .custom_inc(custom_inc),
        .wrap      (wrap),
        .active_inc(active_inc)
    );

    nco_phase_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (active_inc),
        .wrap     (wrap),
        .mclk     (mclk),
        .mclk_tick(mclk_tick)
    );

    nco_fs_div #(
        .DIV_W(DIV_W)
    ) u_fs (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (mclk_tick),
        .fs_tick(fs_tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!mclk && !mclk_tick && !fs_tick)); // R1

endmodule

// File: tb/audio_mclk_nco_test.sv
// Directed bench for audio_mclk_nco: one task per scenario, each checking
// its own results through a port monitor sampled on the falling edge.
module audio_mclk_nco_test;
    localparam int unsigned ACC_W  = 32;
    localparam int unsigned REF_HZ = 250_000_000;
    localparam real         TWO_W  = 4294967296.0;
    localparam int          WIN    = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fam_sel = 1'b0;
    logic             use_custom = 1'b0;
    logic [ACC_W-1:0] custom_inc = '0;
    logic             mclk, mclk_tick, fs_tick;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz bench clock

    audio_mclk_nco #(.ACC_W(ACC_W), .REF_HZ(REF_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .fam_sel(fam_sel), .use_custom(use_custom),
        .custom_inc(custom_inc), .mclk(mclk), .mclk_tick(mclk_tick),
        .fs_tick(fs_tick)
    );

    // ---------------- port monitor ----------------
    logic clr = 1'b0;
    int cyc, n_tick, last_tick, per_min, per_max;
    int hi_min, hi_max, lo_min, lo_max, run, seen_edge;
    int tick_bad, fs_n, fs_bad, ticks_since_fs;
    logic prev_mclk, prev_tick;

    always @(negedge clk) begin
        if (!rst_n) begin
            ticks_since_fs = 0; fs_bad = 0; fs_n = 0; tick_bad = 0;
            prev_mclk = 1'b0; prev_tick = 1'b0;
        end
        if (!rst_n || clr) begin
            cyc = 0; n_tick = 0; last_tick = -1;
            per_min = 1 << 30; per_max = 0;
            hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30; lo_max = 0;
            run = 0; seen_edge = 0;
        end
        if (rst_n) begin
            cyc++;
            if (mclk !== prev_mclk) begin
                if (seen_edge != 0) begin
                    if (prev_mclk) begin
                        if (run < hi_min) hi_min = run;
                        if (run > hi_max) hi_max = run;
                    end else begin
                        if (run < lo_min) lo_min = run;
                        if (run > lo_max) lo_max = run;
                    end
                end
                seen_edge = 1; run = 1;
            end else run++;
            if (mclk_tick) begin
                n_tick++; ticks_since_fs++;
                if (!mclk || prev_mclk || prev_tick) tick_bad++;
                if (last_tick >= 0) begin
                    if (cyc - last_tick < per_min) per_min = cyc - last_tick;
                    if (cyc - last_tick > per_max) per_max = cyc - last_tick;
                end
                last_tick = cyc;
            end else if (mclk && !prev_mclk) tick_bad++;
            if (fs_tick) begin
                fs_n++;
                if (!mclk_tick || ticks_since_fs != 256) fs_bad++;
                ticks_since_fs = 0;
            end
            prev_mclk = mclk; prev_tick = mclk_tick;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic clear_stats();
        clr = 1'b1; cycles(1); clr = 1'b0;
    endtask

    function automatic longint preset(input real f);
        return longint'($floor(f * TWO_W / real'(REF_HZ) + 0.5));
    endfunction

    // Long window at one increment: rate, period bound, phase bound, tick shape.
    task automatic run_fixed(input longint inc, input string req);
        real exp_t;
        int  p_lo, h_lo;
        cycles(200);
        clear_stats();
        cycles(WIN);
        exp_t = real'(cyc) * real'(inc) / TWO_W;
        chk((real'(n_tick) - exp_t <= 1.0) && (exp_t - real'(n_tick) <= 1.0),
            req, "tick count in window", n_tick, longint'(exp_t));
        p_lo = int'($floor(TWO_W / real'(inc)));
        h_lo = int'($floor(TWO_W / 2.0 / real'(inc)));
        chk(per_min >= p_lo && per_max <= int'($ceil(TWO_W / real'(inc))),
            "R8", "period floor/ceil", per_min * 1000 + per_max, p_lo);
        chk(hi_min >= h_lo && lo_min >= h_lo &&
            hi_max <= int'($ceil(TWO_W / 2.0 / real'(inc))) &&
            lo_max <= int'($ceil(TWO_W / 2.0 / real'(inc))),
            "R8", "phase floor/ceil", hi_min * 1000 + lo_min, h_lo);
        chk(tick_bad == 0, "R6", "tick shape errors", tick_bad, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 1'b0; fam_sel = 1'b0; use_custom = 1'b0;
        cycles(5);
        chk(!mclk && !mclk_tick && !fs_tick, "R1", "outputs in reset",
            {mclk, mclk_tick, fs_tick}, 0);
        rst_n = 1'b1;
        cycles(3);
        chk(!mclk, "R1", "mclk low just after reset (phase from zero)", mclk, 0);
    endtask

    task automatic t_family0();
        fam_sel = 1'b0; use_custom = 1'b0;
        run_fixed(preset(12288000.0), "R2");
    endtask

    task automatic t_family1();
        fam_sel = 1'b1; use_custom = 1'b0;
        run_fixed(preset(11289600.0), "R3");
    endtask

    task automatic t_custom();
        custom_inc = 32'h4000_0000; use_custom = 1'b1; fam_sel = 1'b1;
        run_fixed(64'h4000_0000, "R4");
        chk(per_min == 4 && per_max == 4, "R4", "exact period 4", per_max, 4);
        fam_sel = 1'b0;
        cycles(50); clear_stats(); cycles(400);
        chk(per_min == 4 && per_max == 4 && hi_min == 2 && hi_max == 2,
            "R4", "fam_sel ignored in custom mode", per_max, 4);
    endtask

    task automatic t_fs();
        int f0;
        custom_inc = 32'h4000_0000; use_custom = 1'b1;
        f0 = fs_n;
        cycles(256 * 4 * 4);
        chk(fs_n - f0 >= 3 && fs_n - f0 <= 4, "R7", "strobes in 4096 cycles",
            fs_n - f0, 4);
        chk(fs_bad == 0, "R7", "strobe spacing/alignment errors", fs_bad, 0);
    endtask

    task automatic t_switch();
        int gaps[6] = '{37, 53, 71, 29, 97, 61};
        use_custom = 1'b0;
        cycles(100); clear_stats();
        for (int k = 0; k < 60; k++) begin
            fam_sel = ~fam_sel;
            cycles(gaps[k % 6]);
        end
        chk(hi_min >= 10 && lo_min >= 10, "R5", "min phase across family switch",
            (hi_min < lo_min) ? hi_min : lo_min, 10);
        chk(hi_max <= 12 && lo_max <= 12 && per_min >= 20 && per_max <= 23,
            "R5", "phase/period upper bound across switch", per_max, 23);
        custom_inc = 32'h4000_0000; fam_sel = 1'b1;
        clear_stats();
        for (int k = 0; k < 60; k++) begin
            use_custom = ~use_custom;
            cycles(gaps[(k + 2) % 6]);
        end
        chk(hi_min >= 2 && lo_min >= 2, "R5", "min phase custom/preset switch",
            (hi_min < lo_min) ? hi_min : lo_min, 2);
        chk(tick_bad == 0, "R6", "tick shape across switches", tick_bad, 0);
    endtask

    task automatic t_wrap_hold();
        int hi;
        custom_inc = 32'h1000_0000; use_custom = 1'b1;
        cycles(100);
        @(negedge clk);
        while (!mclk_tick) @(negedge clk);
        @(posedge clk); #2;
        custom_inc = 32'h4000_0000;
        hi = 1;
        forever begin
            @(negedge clk);
            if (mclk) hi++; else break;
        end
        chk(hi == 8, "R5", "high phase in progress keeps old rate", hi, 8);
        clear_stats(); cycles(60);
        chk(per_min == 4 && per_max == 4, "R5", "new rate after wrap", per_max, 4);
    endtask

    // ---------------- sequence ----------------
    initial begin
        t_reset();
        t_family0();
        t_family1();
        t_custom();
        t_fs();
        t_switch();
        t_wrap_hold();
        chk(fs_bad == 0, "R7", "strobe errors over whole run", fs_bad, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(190000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule